// File: doc/BRIEF.md
# Pipelined Burst Static Memory with Dual Address Strobes

This block is a cycle-accurate model of a synchronous pipelined burst static memory. Each word is 36 bits wide and split into four 9-bit byte lanes. The array depth is set by a parameter. Every control and data input is taken on the rising clock edge. Each edge is classed as one of the following:
- an idle cycle;
- a deselect;
- a read or write that loads a new external address;
- a read or write that continues or holds an ongoing burst.

A separate 2-bit burst counter produces the low address bits during a burst, in linear or interleaved order.

A new address can be loaded through either of two strobes, a processor strobe and a controller strobe, and the two have a fixed priority. A cycle started by the processor strobe is always a read. A write may follow on the next clock. The controller strobe can start a one-clock write directly. Read data leaves an output register one clock after its address was taken. The bidirectional data bus appears as separate `dq_in`, `dq_out` and `dq_oe` pins. `dq_oe` is a registered drive enable that the asynchronous `drv_en_n` input gates without a clock.

The interface is a pin-level memory bus, not a stream. It has no valid/ready handshake and applies no back-pressure. The master must honour the read latency of one clock and the bus turnaround rules below.

Top module: `pbsram_core`

## Requirements
- R1: The block is selected only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. These three inputs are looked at only on an edge that loads an address. A load with any of them inactive is a deselect.
- R2: If both strobes are low, only the processor strobe `pstb_n` counts. `pstb_n` is ignored whenever `sel_a_n` is high, and such an edge then acts as a burst continuation.
- R3: A load by `pstb_n` is always a read, whatever the write inputs are. On the next edge, with no strobe, the write inputs taken then can write the same address.
- R4: A load by `cstb_n` with `pstb_n` high and a write requested writes in that single edge. `step_n` is ignored on every load edge.
- R5: Lane i is bits [9i+8:9i]. `wr_all_n`=0 writes all four lanes. Otherwise a write needs `wr_lanes_en_n`=0, and only lanes with `lane_n[i]`=0 are written. Unwritten lanes keep their content. With `wr_all_n`=1 and `wr_lanes_en_n`=1 the edge is a read.
- R6: Read data for an address taken at edge k is on `dq_out` with `dq_oe`=1 after edge k+1. Reads on consecutive edges stream one word per clock.
- R7: The burst counter starts at the loaded `addr[1:0]` (S). On each later edge with `step_n`=0 it moves to beat j+1; with `step_n`=1 it holds. The low bits are (S+j) mod 4 when `linear_order`=1 and S xor j when `linear_order`=0. The counter wraps after four beats, and the upper address bits stay at their loaded value.
- R8: When a read is loaded while the block is deselected or idle, `dq_oe` stays 0 in the cycle after that edge, whatever `drv_en_n` is.
- R9: After a deselect is taken at edge d, the previous read data stays driven through the cycle after d. `dq_oe` is 0 after edge d+1.
- R10: In the cycle after a write edge, `dq_oe` is 0 even if `drv_en_n` is 0.
- R11: After a write, reads that continue or hold the burst do not drive the bus. Driving resumes only with a read loaded by a strobe.
- R12: `dq_oe` is 0 whenever `drv_en_n` is 1, with no clock edge needed.
- R13: Reset leaves the block deselected with `dq_oe`=0. While deselected, edges with no strobe do not write the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline registers |
| addr | input | AW | External word address |
| sel_a_n | input | 1 | Select, active low; also gates the processor strobe |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lanes_en_n | input | 1 | Lane write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| linear_order | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| drv_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data register |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench targets the edges where two rules meet:
- **Both strobes low with a write requested.** A design that gave the controller strobe priority would write and blank the bus instead of returning the old word.
- **Processor strobe while `sel_a_n` is high.** A design that treated this as a deselect would never read the next burst address.
- **Deselect followed by a new read.** Here double-cycle deselect and first-cycle blanking overlap, so a bus released one clock early or late shows up as a wrong `dq_oe`.
- **Burst reads in both orders from every start offset, and lane writes under all sixteen lane patterns.** These show up a counter that fails to wrap or XOR, or a write that damages an unselected lane.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_DESEL = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_kind_e;

  // low two address bits of beat 'beat' of a burst starting at 'start'
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       linear);
    logic [1:0] sum;
    sum = start + beat;
    return linear ? sum : (start ^ beat);
  endfunction

endpackage

// File: rtl/pbs_burst_ctr.sv
module pbs_burst_ctr
  import pbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] start_in,
  input  logic       advance,
  input  logic       linear,
  output logic [1:0] cur_lo,
  output logic [1:0] next_lo
);

  logic [1:0] start_q;
  logic [1:0] beat_q;
  logic [1:0] beat_inc;

  assign beat_inc = beat_q + 2'd1;
  assign cur_lo   = burst_lo(start_q, beat_q, linear);
  assign next_lo  = burst_lo(start_q, beat_inc, linear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 2'd0;
      beat_q  <= 2'd0;
    end else if (load) begin
      start_q <= start_in;
      beat_q  <= 2'd0;
    end else if (advance) begin
      beat_q  <= beat_inc;
    end
  end

endmodule

// File: rtl/pbs_cycle_decode.sv
module pbs_cycle_decode
  import pbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             step_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             wr_lanes_en_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             active_q,
  output acc_kind_e        kind,
  output logic             load,
  output logic             selected,
  output logic             use_next,
  output logic [LANES-1:0] lane_mask
);

  logic proc_take;
  logic ctrl_take;
  logic wr_req;

  // processor strobe only counts when the first select is active
  assign proc_take = !pstb_n && !sel_a_n;
  assign ctrl_take = !cstb_n && !proc_take;
  assign load      = proc_take || ctrl_take;
  assign selected  = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    if (!wr_all_n)           lane_mask = '1;
    else if (!wr_lanes_en_n) lane_mask = ~lane_n;
    else                     lane_mask = '0;
  end

  assign wr_req = |lane_mask;

  always_comb begin
    kind     = ACC_NONE;
    use_next = 1'b0;
    if (load) begin
      if (!selected)      kind = ACC_DESEL;
      else if (proc_take) kind = ACC_READ;
      else                kind = wr_req ? ACC_WRITE : ACC_READ;
    end else if (active_q) begin
      kind     = wr_req ? ACC_WRITE : ACC_READ;
      use_next = !step_n;
    end
  end

endmodule

// File: rtl/pbs_lane_array.sv
module pbs_lane_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_mask,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g])
        lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    // output register sees the content before any write on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q <= '0;
      else if (rd_en) lane_q <= lane_mem[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbs_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_lanes_en_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             linear_order,
  input  logic             drv_en_n,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);

  acc_kind_e        kind;
  logic             load;
  logic             selected;
  logic             use_next;
  logic [LANES-1:0] lane_mask;

  logic             active_q;
  logic [AW-3:0]    base_hi_q;
  logic [1:0]       cur_lo;
  logic [1:0]       next_lo;
  logic [AW-1:0]    acc_addr;

  logic             rd_pend_q;
  logic [AW-1:0]    rd_addr_q;
  logic             drive_pend_q;
  logic             drive_q;
  logic             wr_q;
  logic             hold_q;

  logic             is_read;
  logic             is_write;
  logic             take_addr;

  pbs_cycle_decode #(.LANES(LANES)) u_dec (
    .pstb_n        (pstb_n),
    .cstb_n        (cstb_n),
    .step_n        (step_n),
    .sel_a_n       (sel_a_n),
    .sel_b         (sel_b),
    .sel_c_n       (sel_c_n),
    .wr_all_n      (wr_all_n),
    .wr_lanes_en_n (wr_lanes_en_n),
    .lane_n        (lane_n),
    .active_q      (active_q),
    .kind          (kind),
    .load          (load),
    .selected      (selected),
    .use_next      (use_next),
    .lane_mask     (lane_mask)
  );

  assign is_read   = (kind == ACC_READ);
  assign is_write  = (kind == ACC_WRITE);
  assign take_addr = load && selected;

  pbs_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_addr),
    .start_in (addr[1:0]),
    .advance  (!load && active_q && !step_n),
    .linear   (linear_order),
    .cur_lo   (cur_lo),
    .next_lo  (next_lo)
  );

  always_comb begin
    if (load) acc_addr = addr;
    else      acc_addr = {base_hi_q, (use_next ? next_lo : cur_lo)};
  end

  pbs_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (is_write),
    .wr_addr (acc_addr),
    .wr_mask (lane_mask),
    .wr_data (dq_in),
    .rd_en   (rd_pend_q),
    .rd_addr (rd_addr_q),
    .rd_data (dq_out)
  );

  // selection and burst base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_hi_q <= '0;
    end else if (load) begin
      active_q <= selected;
      if (selected) base_hi_q <= addr[AW-1:2];
    end
  end

  // read / drive pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q    <= 1'b0;
      rd_addr_q    <= '0;
      drive_pend_q <= 1'b0;
      drive_q      <= 1'b0;
      wr_q         <= 1'b0;
      hold_q       <= 1'b0;
    end else begin
      rd_pend_q    <= is_read;
      rd_addr_q    <= acc_addr;
      drive_pend_q <= is_read && (load || !hold_q);
      drive_q      <= drive_pend_q;
      wr_q         <= is_write;
      if (is_write)  hold_q <= 1'b1;
      else if (load) hold_q <= 1'b0;
    end
  end

  assign dq_oe = drive_q && !wr_q && !drv_en_n;

endmodule

// File: rtl/pbsram_core_checks.sv
module pbsram_core_checks #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             pstb_n,
  input logic             cstb_n,
  input logic             wr_all_n,
  input logic             wr_lanes_en_n,
  input logic [LANES-1:0] lane_n,
  input logic             drv_en_n,
  input logic             dq_oe,
  input logic             active_q,
  input logic             wr_q
);

  logic ld_now;
  logic sel_now;
  logic wreq_now;

  assign ld_now   = (!pstb_n && !sel_a_n) || !cstb_n;
  assign sel_now  = !sel_a_n && sel_b && !sel_c_n;
  assign wreq_now = !wr_all_n || (!wr_lanes_en_n && (lane_n != '1));

  // R12: the asynchronous enable gates the drive
  a_r12_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !drv_en_n);

  // R3: a processor-strobe load never writes
  a_r3_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && !sel_a_n) |=> !wr_q);

  // R10: controller write blanks the bus in the following cycle
  a_r10_write_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (pstb_n && !cstb_n && sel_now && wreq_now) |=> !dq_oe);

  // R9: deselect releases the bus after the following edge
  a_r9_dcd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_now && !sel_now) |=> ##1 !dq_oe);

  // R8: first cycle of a read loaded from the deselected state is blank
  a_r8_first_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && ld_now && sel_now) |=> !dq_oe);

  // R11: a non-loaded access right after a write does not drive
  a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !ld_now) |=> ##1 !dq_oe);

endmodule

bind pbsram_core pbsram_core_checks #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_a_n       (sel_a_n),
  .sel_b         (sel_b),
  .sel_c_n       (sel_c_n),
  .pstb_n        (pstb_n),
  .cstb_n        (cstb_n),
  .wr_all_n      (wr_all_n),
  .wr_lanes_en_n (wr_lanes_en_n),
  .lane_n        (lane_n),
  .drv_en_n      (drv_en_n),
  .dq_oe         (dq_oe),
  .active_q      (active_q),
  .wr_q          (wr_q)
);

// File: tb/pbsram_core_test.sv
`timescale 1ns/1ps
module pbsram_core_test;
  localparam int DEPTH = 64;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int AW    = 6;
  localparam int DW    = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic [AW-1:0]    addr;
  logic             sel_a_n, sel_b, sel_c_n;
  logic             pstb_n, cstb_n, step_n;
  logic             wr_all_n, wr_lanes_en_n;
  logic [LANES-1:0] lane_n;
  logic             linear_order, drv_en_n;
  logic [DW-1:0]    dq_in, dq_out;
  logic             dq_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];

  pbsram_core #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lanes_en_n(wr_lanes_en_n), .lane_n(lane_n),
    .linear_order(linear_order), .drv_en_n(drv_en_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_oe(input string req, input logic exp);
    chk(req, {35'd0, dq_oe}, {35'd0, exp});
  endtask

  task automatic idle();
    pstb_n = 1; cstb_n = 1; step_n = 1;
    wr_all_n = 1; wr_lanes_en_n = 1; lane_n = '1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    addr = '0; dq_in = '0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    logic [63:0] v;
    v = 64'(a) * 64'd2654435761 + 64'(k) * 64'd40503 + 64'h5A5;
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic wa_n, input logic we_n,
                                          input logic [LANES-1:0] ln);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < LANES; i++)
      if (!wa_n || (!we_n && !ln[i])) r[i*LW +: LW] = d[i*LW +: LW];
    return r;
  endfunction

  task automatic ctrl_wr(input int a, input logic [DW-1:0] d, input logic wa_n,
                         input logic we_n, input logic [LANES-1:0] ln);
    idle();
    cstb_n = 0; addr = AW'(a); dq_in = d; step_n = 0;
    wr_all_n = wa_n; wr_lanes_en_n = we_n; lane_n = ln;
    tick();
    ref_mem[a] = merge(ref_mem[a], d, wa_n, we_n, ln);
  endtask

  task automatic rd_check(input int a, input string req);
    idle();
    cstb_n = 0; addr = AW'(a);
    tick();
    idle();
    tick();
    chk_oe(req, 1'b1);
    chk(req, dq_out, ref_mem[a]);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    idle();
    linear_order = 1; drv_en_n = 0; rst_n = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk_oe("R13 reset drive", 1'b0);
    tick();
    chk_oe("R13 idle after reset", 1'b0);

    // R4/R5: fill through global writes, one per clock
    for (int a = 0; a < DEPTH; a++) ctrl_wr(a, pat(a, 1), 1'b0, 1'b1, '1);

    // R6: back-to-back reads, one word per clock
    for (int i = 0; i <= DEPTH; i++) begin
      idle();
      if (i < DEPTH) begin cstb_n = 0; addr = AW'(i); end
      tick();
      if (i > 0) begin
        chk_oe("R6 stream drive", 1'b1);
        chk("R6 stream data", dq_out, ref_mem[i-1]);
      end
    end

    // R5: every lane pattern
    for (int m = 0; m < 16; m++) begin
      ctrl_wr(m, pat(m, 2), 1'b1, 1'b0, 4'(m));
      rd_check(m, "R5 lane mask");
    end
    ctrl_wr(20, pat(20, 3), 1'b1, 1'b1, 4'h0);
    rd_check(20, "R5 lanes without enable");
    ctrl_wr(21, pat(21, 3), 1'b0, 1'b1, 4'hF);
    rd_check(21, "R5 global override");

    // R3: processor load with write inputs is a read
    idle(); pstb_n = 0; addr = 6'd31; wr_all_n = 0; dq_in = pat(31, 9);
    tick();
    idle(); tick();
    chk_oe("R3 proc load reads", 1'b1);
    chk("R3 proc load reads", dq_out, ref_mem[31]);
    rd_check(31, "R3 no write on proc load");
    // R3: write on the clock after the processor load
    idle(); pstb_n = 0; addr = 6'd30; wr_all_n = 0; dq_in = pat(30, 4);
    tick();
    idle(); wr_all_n = 0; dq_in = pat(30, 5);
    tick();
    ref_mem[30] = pat(30, 5);
    rd_check(30, "R3 follow-on write");

    // R2: both strobes low, processor wins
    idle(); pstb_n = 0; cstb_n = 0; addr = 6'd32; wr_all_n = 0; dq_in = pat(32, 9);
    tick();
    idle(); tick();
    chk_oe("R2 priority read", 1'b1);
    chk("R2 priority read", dq_out, ref_mem[32]);
    rd_check(32, "R2 no write");
    // R2: processor strobe ignored when first select is high
    linear_order = 1;
    idle(); cstb_n = 0; addr = 6'd33;
    tick();
    idle(); pstb_n = 0; sel_a_n = 1; step_n = 0; addr = 6'd0;
    tick();
    idle(); tick();
    chk_oe("R2 ignored strobe continues", 1'b1);
    chk("R2 ignored strobe continues", dq_out, ref_mem[34]);

    // R7: burst reads, both orders, every start
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        idle(); linear_order = lin[0];
        tick();
        idle(); cstb_n = 0; step_n = 0; addr = {4'h5, 2'(s)};
        tick();
        for (int j = 1; j <= 5; j++) begin
          logic [1:0] b;
          logic [1:0] lo;
          idle();
          if (j <= 4) step_n = 0;
          tick();
          b  = 2'(j - 1);
          lo = lin[0] ? 2'(s) + b : 2'(s) ^ b;
          chk("R7 burst order", dq_out, ref_mem[{4'h5, lo}]);
        end
      end
    end

    // R4/R7: linear burst write from start 2, then a held write
    linear_order = 1;
    idle(); cstb_n = 0; step_n = 0; wr_all_n = 0; addr = 6'd50; dq_in = pat(50, 7);
    tick(); ref_mem[50] = pat(50, 7);
    idle(); step_n = 0; wr_all_n = 0; dq_in = pat(51, 7); tick(); ref_mem[51] = pat(51, 7);
    idle(); step_n = 0; wr_all_n = 0; dq_in = pat(48, 7); tick(); ref_mem[48] = pat(48, 7);
    idle(); step_n = 0; wr_all_n = 0; dq_in = pat(49, 7); tick(); ref_mem[49] = pat(49, 7);
    idle(); step_n = 1; wr_all_n = 0; dq_in = pat(49, 8); tick(); ref_mem[49] = pat(49, 8);
    for (int a = 48; a < 52; a++) rd_check(a, "R4 burst write");

    // R1/R8/R9: each select input deselects
    for (int v = 0; v < 3; v++) begin
      idle(); cstb_n = 0; addr = AW'(40 + v);
      tick();
      idle(); cstb_n = 0;
      if (v == 0) sel_a_n = 1; else if (v == 1) sel_b = 0; else sel_c_n = 1;
      tick();
      chk_oe("R9 drive held one cycle", 1'b1);
      chk("R9 data held", dq_out, ref_mem[40 + v]);
      idle(); tick();
      chk_oe("R1 R9 released", 1'b0);
      idle(); cstb_n = 0; addr = AW'(44 + v);
      tick();
      chk_oe("R8 first cycle blank", 1'b0);
      idle(); tick();
      chk_oe("R8 then driven", 1'b1);
      chk("R8 data", dq_out, ref_mem[44 + v]);
    end

    // R13: deselected, non-load write cycles change nothing
    idle(); cstb_n = 0; sel_b = 0; tick();
    for (int i = 0; i < 3; i++) begin
      idle(); wr_all_n = 0; step_n = 0; dq_in = '1; tick();
      chk_oe("R13 deselected quiet", 1'b0);
    end
    for (int a = 44; a < 48; a++) rd_check(a, "R13 no write while deselected");

    // R10/R11: write turnaround
    idle(); cstb_n = 0; addr = 6'd52; tick();
    idle(); cstb_n = 0; addr = 6'd53; wr_all_n = 0; dq_in = pat(53, 6); tick();
    ref_mem[53] = pat(53, 6);
    chk_oe("R10 write blanks bus", 1'b0);
    idle(); tick();
    idle(); tick();
    chk_oe("R11 continued read stays off", 1'b0);
    idle(); cstb_n = 0; addr = 6'd53; tick();
    idle(); tick();
    chk_oe("R11 strobed read drives", 1'b1);
    chk("R11 data", dq_out, ref_mem[53]);

    // R12: asynchronous enable
    idle(); cstb_n = 0; addr = 6'd54; tick();
    idle(); tick();
    chk_oe("R12 enabled", 1'b1);
    drv_en_n = 1; #1;
    chk_oe("R12 disabled", 1'b0);
    drv_en_n = 0; #1;
    chk_oe("R12 re-enabled", 1'b1);

    finished = 1'b1;
    report();
    $finish;
  end

endmodule